// File: doc/BRIEF.md
# Bus-Matching Width Converter with Selectable Lane Order

This block sits on both sides of a 36-bit FIFO core and lets the external ports run narrower than the core. On the write side it packs 18-bit or 9-bit external words into 36-bit core words. On the read side it splits 36-bit core words into 18-bit or 9-bit external words. A 36-bit mode passes words straight through. Every interface uses a valid/ready handshake, and a transfer takes place on a rising clock edge where both valid and ready are high.

The lane widths and the order of the narrow pieces come from configuration pins. These pins are captured only while master reset is high. Partial reset clears the data in flight and keeps the captured configuration. Only one side of the path can be narrow at a time. In big-endian order the most significant piece moves first. In little-endian order the least significant piece moves first. Pieces sit on 9-bit or 18-bit boundaries of the core word, and a narrow external word uses the low bits of its 36-bit data bus.

Top module: `bm_converter`

## Requirements
- R1: Width codes are 00 for 36 bits, 01 for 18 bits, 10 for 9 bits and 11 for 36 bits. `cfg_big_endian` = 1 selects big-endian order. These pins are captured on every clock edge where `rst_master` is high. At all other times, including during partial reset, they have no effect.
- R2: If the captured input width is narrow, the output width is forced to 36 bits, whatever the output code says.
- R3: In 36-bit mode, each external input word reaches the core unchanged. Each core word reaches the external output unchanged.
- R4: With 18-bit input, two accepted words form one core word. In big-endian order the first word fills bits 35:18. In little-endian order the first word fills bits 17:0. Bits 35:18 of `ext_in_data` are ignored.
- R5: With 9-bit input, four accepted words form one core word. In big-endian order the first word fills bits 35:27 and the last fills bits 8:0. Little-endian order reverses this. Bits 35:9 of `ext_in_data` are ignored.
- R6: A packed word is presented only once all of its pieces have arrived. It stays on `core_wr_data` with `core_wr_valid` high until `core_wr_ready` is high. While it is held and not being taken, `ext_in_ready` is low.
- R7: With 18-bit output, each core word gives two output words. In big-endian order bits 35:18 go first. In little-endian order bits 17:0 go first. Bits 35:18 of `ext_out_data` are zero.
- R8: With 9-bit output, each core word gives four output words. In big-endian order bits 35:27 go first. In little-endian order bits 8:0 go first. Bits 35:9 of `ext_out_data` are zero.
- R9: `core_rd_ready` is high only in two cases: no core word is held, or the last piece of the held word is being accepted in the same cycle.
- R10: Partial reset discards a partly packed word, a held word and any pieces not yet sent. The captured configuration is kept.
- R11: While `ext_out_valid` is high and `ext_out_ready` is low, `ext_out_data` and `ext_out_valid` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_master | input | 1 | Synchronous master reset; captures configuration and clears data |
| rst_partial | input | 1 | Synchronous partial reset; clears data and keeps configuration |
| cfg_in_width | input | 2 | Input width code |
| cfg_out_width | input | 2 | Output width code |
| cfg_big_endian | input | 1 | 1 selects big-endian piece order |
| ext_in_valid | input | 1 | External input word valid |
| ext_in_ready | output | 1 | Converter can accept an external word |
| ext_in_data | input | 36 | External input word; narrow words use the low bits |
| core_wr_valid | output | 1 | Packed word valid toward the core |
| core_wr_ready | input | 1 | Core accepts the packed word |
| core_wr_data | output | 36 | Packed word |
| core_rd_valid | input | 1 | Core offers a word |
| core_rd_ready | output | 1 | Converter takes the core word |
| core_rd_data | input | 36 | Core word |
| ext_out_valid | output | 1 | External output word valid |
| ext_out_ready | input | 1 | External consumer accepts the word |
| ext_out_data | output | 36 | External output word; narrow words use the low bits |

## Verification
Every legal pairing of widths is run in both piece orders. Random valid and ready patterns on all four handshakes produce stalls at the start, middle and end of a word. Stalls at each point show whether the piece counter and the hold logic treat the last piece differently from the others. The upper bits of narrow input buses carry random values, so a packer that reads the wrong lanes gives wrong core words. Both piece orders use the same data, so swapped or mirrored slice positions show up. An illegal code pair, configuration pins changed after reset, and partial resets issued in the middle of a word separate captured configuration from live pins and show that stale pieces are dropped.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int WORD_W = 36;
    localparam int HALF_W = WORD_W / 2;
    localparam int QTR_W  = WORD_W / 4;

    typedef enum logic [1:0] {
        LANE_36 = 2'b00,
        LANE_18 = 2'b01,
        LANE_9  = 2'b10
    } lane_e;

    typedef struct packed {
        lane_e in_lane;
        lane_e out_lane;
        logic  big_end;
    } bm_cfg_t;

    function automatic lane_e decode_lane(input logic [1:0] code);
        case (code)
            2'b01:   return LANE_18;
            2'b10:   return LANE_9;
            default: return LANE_36;
        endcase
    endfunction

    // number of pieces in a core word, minus one
    function automatic logic [1:0] last_idx(input lane_e lane);
        case (lane)
            LANE_18: return 2'd1;
            LANE_9:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // slice position inside the core word for the idx-th transferred piece
    function automatic logic [1:0] piece_pos(input lane_e lane, input logic [1:0] idx,
                                             input logic big);
        return big ? (last_idx(lane) - idx) : idx;
    endfunction

    function automatic logic [WORD_W-1:0] put_piece(input logic [WORD_W-1:0] word,
                                                    input logic [WORD_W-1:0] data,
                                                    input lane_e lane,
                                                    input logic [1:0] pos);
        logic [WORD_W-1:0] r;
        r = word;
        case (lane)
            LANE_18: r[int'(pos)*HALF_W +: HALF_W] = data[HALF_W-1:0];
            LANE_9:  r[int'(pos)*QTR_W +: QTR_W]   = data[QTR_W-1:0];
            default: r = data;
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] get_piece(input logic [WORD_W-1:0] word,
                                                    input lane_e lane,
                                                    input logic [1:0] pos);
        logic [WORD_W-1:0] r;
        r = '0;
        case (lane)
            LANE_18: r[HALF_W-1:0] = word[int'(pos)*HALF_W +: HALF_W];
            LANE_9:  r[QTR_W-1:0]  = word[int'(pos)*QTR_W +: QTR_W];
            default: r = word;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_master,
    input  logic [1:0] in_code,
    input  logic [1:0] out_code,
    input  logic       big_code,
    output bm_cfg_t    cfg
);

    always_ff @(posedge clk) begin
        if (rst_master) begin
            cfg.in_lane  <= decode_lane(in_code);
            cfg.out_lane <= (decode_lane(in_code) != LANE_36) ? LANE_36 : decode_lane(out_code);
            cfg.big_end  <= big_code;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst_master)
        !$past(rst_master) |-> $stable(cfg)) else $error("cfg changed outside reset"); // R1

    AST_ONE_SIDE_WIDE: assert property (@(posedge clk) disable iff (rst_master)
        (cfg.in_lane != LANE_36) |-> (cfg.out_lane == LANE_36)) else $error("both sides narrow"); // R2

endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_e             lane,
    input  logic              big_end,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_data
);

    logic [1:0]        cnt;
    logic [WORD_W-1:0] acc;
    logic              held;
    logic              fire;
    logic              last;

    assign in_ready = !held || wr_ready;
    assign fire     = in_valid && in_ready;
    assign last     = (cnt == last_idx(lane));
    assign wr_valid = held;
    assign wr_data  = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            acc  <= '0;
            held <= 1'b0;
        end else begin
            if (held && wr_ready)
                held <= 1'b0;
            if (fire) begin
                acc <= put_piece(acc, in_data, lane, piece_pos(lane, cnt, big_end));
                if (last) begin
                    cnt  <= '0;
                    held <= 1'b1;
                end else begin
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

    AST_PACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))) else $error("packed word moved"); // R6

    AST_PACK_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> !in_ready) else $error("input taken while held"); // R6

    AST_PACK_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_idx(lane)) else $error("pack counter out of range"); // R5

endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_e             lane,
    input  logic              big_end,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    logic [1:0]        idx;
    logic [WORD_W-1:0] word;
    logic              hold;
    logic              last;
    logic              out_fire;
    logic              rd_fire;

    assign last      = (idx == last_idx(lane));
    assign out_valid = hold;
    assign out_fire  = hold && out_ready;
    assign rd_ready  = !hold || (out_ready && last);
    assign rd_fire   = rd_valid && rd_ready;
    assign out_data  = get_piece(word, lane, piece_pos(lane, idx, big_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            word <= '0;
            hold <= 1'b0;
        end else begin
            if (out_fire) begin
                if (last) begin
                    idx  <= '0;
                    hold <= 1'b0;
                end else begin
                    idx <= idx + 2'd1;
                end
            end
            if (rd_fire) begin
                hold <= 1'b1;
                word <= rd_data;
            end
        end
    end

    AST_SLICE_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("slice moved under stall"); // R11

    AST_NARROW9_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && lane == LANE_9) |-> (out_data[WORD_W-1:QTR_W] == '0)) else $error("upper bits set"); // R8

    AST_NARROW18_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && lane == LANE_18) |-> (out_data[WORD_W-1:HALF_W] == '0)) else $error("upper bits set"); // R7

    AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(word)) else $error("held word replaced"); // R9

endmodule

// File: rtl/bm_converter.sv
module bm_converter
    import bm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_master,
    input  logic        rst_partial,
    input  logic [1:0]  cfg_in_width,
    input  logic [1:0]  cfg_out_width,
    input  logic        cfg_big_endian,
    input  logic        ext_in_valid,
    output logic        ext_in_ready,
    input  logic [35:0] ext_in_data,
    output logic        core_wr_valid,
    input  logic        core_wr_ready,
    output logic [35:0] core_wr_data,
    input  logic        core_rd_valid,
    output logic        core_rd_ready,
    input  logic [35:0] core_rd_data,
    output logic        ext_out_valid,
    input  logic        ext_out_ready,
    output logic [35:0] ext_out_data
);

    bm_cfg_t cfg;
    logic    data_rst;

    assign data_rst = rst_master || rst_partial;

    bm_cfg_latch u_cfg (
        .clk        (clk),
        .rst_master (rst_master),
        .in_code    (cfg_in_width),
        .out_code   (cfg_out_width),
        .big_code   (cfg_big_endian),
        .cfg        (cfg)
    );

    bm_pack u_pack (
        .clk      (clk),
        .rst      (data_rst),
        .lane     (cfg.in_lane),
        .big_end  (cfg.big_end),
        .in_valid (ext_in_valid),
        .in_ready (ext_in_ready),
        .in_data  (ext_in_data),
        .wr_valid (core_wr_valid),
        .wr_ready (core_wr_ready),
        .wr_data  (core_wr_data)
    );

    bm_unpack u_unpack (
        .clk       (clk),
        .rst       (data_rst),
        .lane      (cfg.out_lane),
        .big_end   (cfg.big_end),
        .rd_valid  (core_rd_valid),
        .rd_ready  (core_rd_ready),
        .rd_data   (core_rd_data),
        .out_valid (ext_out_valid),
        .out_ready (ext_out_ready),
        .out_data  (ext_out_data)
    );

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(data_rst) |-> (!core_wr_valid && !ext_out_valid)) else $error("data after reset"); // R10

endmodule

// File: tb/bm_converter_test.sv
module bm_converter_test;

    logic        clk = 1'b0;
    logic        rst_master = 1'b1;
    logic        rst_partial = 1'b0;
    logic [1:0]  cfg_in_width = 2'b00;
    logic [1:0]  cfg_out_width = 2'b00;
    logic        cfg_big_endian = 1'b0;
    logic        ext_in_valid = 1'b0;
    logic        ext_in_ready;
    logic [35:0] ext_in_data = '0;
    logic        core_wr_valid;
    logic        core_wr_ready = 1'b0;
    logic [35:0] core_wr_data;
    logic        core_rd_valid = 1'b0;
    logic        core_rd_ready;
    logic [35:0] core_rd_data = '0;
    logic        ext_out_valid;
    logic        ext_out_ready = 1'b0;
    logic [35:0] ext_out_data;

    always #4 clk = ~clk;

    bm_converter uut (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tag_in = "R3";
    string tag_out = "R3";

    // reference model state
    int          m_in_w = 36;
    int          m_out_w = 36;
    bit          m_be = 0;
    int          m_cnt = 0;
    logic [35:0] m_acc = '0;
    logic [35:0] wr_q[$];
    logic [35:0] out_q[$];

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int width_of(input logic [1:0] c);
        return (c == 2'b01) ? 18 : (c == 2'b10) ? 9 : 36;
    endfunction

    always @(negedge clk) begin
        #3;
        if (rst_master) begin
            m_in_w  = width_of(cfg_in_width);
            m_out_w = (m_in_w != 36) ? 36 : width_of(cfg_out_width);
            m_be    = cfg_big_endian;
        end
        if (rst_master || rst_partial) begin
            m_cnt = 0; m_acc = '0;
            wr_q.delete(); out_q.delete();
        end else begin
            int n_in;
            int n_out;
            bit wr_fire;
            bit in_fire;
            bit rd_fire;
            bit out_fire;
            n_in  = 36 / m_in_w;
            n_out = 36 / m_out_w;
            // write side
            chk(core_wr_valid == (wr_q.size() > 0), "R6 wr_valid", 36'(core_wr_valid), 36'(wr_q.size() > 0));
            chk(ext_in_ready == (wr_q.size() == 0 || core_wr_ready), "R6 in_ready",
                36'(ext_in_ready), 36'(wr_q.size() == 0 || core_wr_ready));
            wr_fire = core_wr_valid && core_wr_ready;
            in_fire = ext_in_valid && ext_in_ready;
            if (core_wr_valid && wr_q.size() > 0)
                chk(core_wr_data == wr_q[0], {tag_in, " packed word"}, core_wr_data, wr_q[0]);
            if (wr_fire && wr_q.size() > 0) void'(wr_q.pop_front());
            if (in_fire) begin
                int pos;
                pos = m_be ? (n_in - 1 - m_cnt) : m_cnt;
                for (int b = 0; b < m_in_w; b++) m_acc[pos*m_in_w + b] = ext_in_data[b];
                m_cnt++;
                if (m_cnt == n_in) begin
                    wr_q.push_back(m_acc);
                    m_cnt = 0;
                end
            end
            // read side
            chk(ext_out_valid == (out_q.size() > 0), "R11 out_valid", 36'(ext_out_valid), 36'(out_q.size() > 0));
            chk(core_rd_ready == (out_q.size() == 0 || (ext_out_ready && out_q.size() == 1)), "R9 rd_ready",
                36'(core_rd_ready), 36'(out_q.size() == 0 || (ext_out_ready && out_q.size() == 1)));
            out_fire = ext_out_valid && ext_out_ready;
            rd_fire  = core_rd_valid && core_rd_ready;
            if (ext_out_valid && out_q.size() > 0)
                chk(ext_out_data == out_q[0], {tag_out, "/R11 slice"}, ext_out_data, out_q[0]);
            if (out_fire && out_q.size() > 0) void'(out_q.pop_front());
            if (rd_fire) begin
                for (int k = 0; k < n_out; k++) begin
                    int pos;
                    logic [35:0] s;
                    pos = m_be ? (n_out - 1 - k) : k;
                    s = '0;
                    for (int b = 0; b < m_out_w; b++) s[b] = core_rd_data[pos*m_out_w + b];
                    out_q.push_back(s);
                end
            end
        end
    end

    function automatic logic [35:0] rnd36();
        logic [31:0] lo;
        logic [31:0] hi;
        lo = $urandom();
        hi = $urandom();
        return {hi[3:0], lo};
    endfunction

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ext_in_valid  = ($urandom() % 4) != 0;
            ext_in_data   = rnd36();
            core_wr_ready = ($urandom() % 3) != 0;
            core_rd_valid = ($urandom() % 3) != 0;
            core_rd_data  = rnd36();
            ext_out_ready = ($urandom() % 4) != 0;
        end
    endtask

    task automatic mreset(input logic [1:0] iw, input logic [1:0] ow, input logic be);
        @(negedge clk);
        rst_master = 1'b1;
        ext_in_valid = 1'b0; core_rd_valid = 1'b0;
        cfg_in_width = iw; cfg_out_width = ow; cfg_big_endian = be;
        repeat (2) @(negedge clk);
        rst_master = 1'b0;
        // R1: scramble pins after capture; they must be ignored
        cfg_in_width = ~iw; cfg_out_width = ~ow; cfg_big_endian = ~be;
        #3;
        chk(!core_wr_valid && !ext_out_valid, "R1 reset state", {34'b0, core_wr_valid, ext_out_valid}, '0);
    endtask

    task automatic preset();
        @(negedge clk);
        rst_partial = 1'b1;
        cfg_in_width = 2'b01; cfg_out_width = 2'b10; cfg_big_endian = ~cfg_big_endian;
        @(negedge clk);
        rst_partial = 1'b0;
        #3;
        chk(!core_wr_valid && !ext_out_valid, "R10 partial reset", {34'b0, core_wr_valid, ext_out_valid}, '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tag_in = "R3 R1"; tag_out = "R3 R1";
        mreset(2'b00, 2'b00, 1'b0); run(600);
        mreset(2'b11, 2'b11, 1'b1); run(300);
        tag_in = "R4 R1";
        mreset(2'b01, 2'b00, 1'b1); run(600);
        mreset(2'b01, 2'b00, 1'b0); run(600);
        tag_in = "R5 R1";
        mreset(2'b10, 2'b00, 1'b1); run(600);
        mreset(2'b10, 2'b00, 1'b0); run(600);
        tag_in = "R3 R1"; tag_out = "R7 R1";
        mreset(2'b00, 2'b01, 1'b1); run(600);
        mreset(2'b00, 2'b01, 1'b0); run(600);
        tag_out = "R8 R1";
        mreset(2'b00, 2'b10, 1'b1); run(600);
        mreset(2'b00, 2'b10, 1'b0); run(600);
        tag_in = "R2 R5"; tag_out = "R2 R3";
        mreset(2'b10, 2'b10, 1'b1); run(600);
        mreset(2'b01, 2'b01, 1'b0); run(600);
        tag_in = "R10 R5"; tag_out = "R10 R3";
        mreset(2'b10, 2'b00, 1'b1);
        for (int j = 0; j < 8; j++) begin run(37 + j); preset(); end
        run(300);
        tag_in = "R10 R3"; tag_out = "R10 R8";
        mreset(2'b00, 2'b10, 1'b0);
        for (int j = 0; j < 8; j++) begin run(29 + j); preset(); end
        run(300);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule